// File: doc/BRIEF.md
# Serial ChaCha Permutation Engine

This block applies the ChaCha double-round permutation to a 512-bit state held as sixteen 32-bit words. A caller presents the whole state on a parallel input and pulses a start strobe. The engine then works through ten double rounds, each made of four column quarter-rounds followed by four diagonal quarter-rounds. The permuted state appears on a parallel output, marked by a one-cycle completion pulse. The input state is not added back into the result; any such finishing step belongs to the caller.

The datapath is deliberately narrow. It has one 32-bit adder, one XOR and one variable rotator, and it performs a single add-xor-rotate step per clock. A small step decoder turns a 5-bit step counter into three word indices and a rotate amount. A quarter-round therefore takes four cycles, a double round takes 32 cycles, and a full permutation takes 320 cycles. This costs latency and saves the area of four parallel quarter-round pipelines.

Top module: `chacha_perm_core`

## Requirements
- R1: After a synchronous active-high reset, `busy_o` and `done_o` are 0 and `state_o` is all zeros.
- R2: `done_o` is high for exactly one cycle. That cycle begins 320 clock edges after the edge that accepted `start_i`.
- R3: `state_o` equals the input after `DOUBLE_ROUNDS` (10) double rounds with no feed-forward, where word x_i sits at bits [32*i+31 : 32*i] of `state_i` and `state_o`. All additions wrap modulo 2^32.
- R4: Each quarter-round on words (a,b,c,d) runs the steps a+=b, d=rotl(d^a,16), c+=d, b=rotl(b^c,12), a+=b, d=rotl(d^a,8), c+=d, b=rotl(b^c,7), in that order. The rotate amounts therefore repeat 16, 12, 8, 7 over consecutive steps.
- R5: The column half of a double round uses the word sets (0,4,8,12), (1,5,9,13), (2,6,10,14) and (3,7,11,15), in that order.
- R6: The diagonal half follows the column half and uses the sets (0,5,10,15), (1,6,11,12), (2,7,8,13) and (3,4,9,14), in that order.
- R7: `busy_o` is high from the cycle after an accepted start through the cycle of the last step. It is low in the `done_o` cycle.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The state is not reloaded and the completion time does not move.
- R9: An all-zero input state yields an all-zero output state.
- R10: While idle and without a start, `state_o` holds the last result unchanged.
- R11: A reset during a run aborts the run: no `done_o` follows, and the next start produces a correct result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, sampled only when idle |
| state_i | input | 512 | Input state, word i in bits [32*i+31:32*i] |
| busy_o | output | 1 | Permutation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| state_o | output | 512 | Current/permuted state, same word layout |

## Verification
The assertions assume that `rst` is held for at least one full cycle and that inputs change only away from the rising edge. They also assume `start_i` may arrive in any cycle, including while busy, so the properties on counter advance and idle-state stability must hold whatever the strobe does. The stimulus drives all inputs on the falling edge. It keeps resets at two cycles and sends extra start pulses carrying different data while busy, which tests that these pulses are ignored rather than avoiding them.

// File: rtl/chacha_perm_pkg.sv
package chacha_perm_pkg;

    localparam int WORD_W       = 32;
    localparam int NUM_WORDS    = 16;
    localparam int IDX_W        = $clog2(NUM_WORDS);
    localparam int STEPS_PER_DR = 32;
    localparam int STEP_W       = $clog2(STEPS_PER_DR);
    localparam int ROT_W        = $clog2(WORD_W);
    localparam int STATE_W      = WORD_W * NUM_WORDS;

    typedef logic [WORD_W-1:0]                 word_t;
    typedef logic [NUM_WORDS-1:0][WORD_W-1:0]  state_t;
    typedef logic [IDX_W-1:0]                  idx_t;

    // Operands of one add-xor-rotate step.
    typedef struct packed {
        idx_t             tgt;  // receives tgt + src
        idx_t             src;  // addend
        idx_t             mix;  // receives rotl(mix ^ sum, rot)
        logic [ROT_W-1:0] rot;
    } step_ctl_t;

endpackage

// File: rtl/chacha_step_table.sv
module chacha_step_table
    import chacha_perm_pkg::*;
(
    input  logic [STEP_W-1:0] step_i,
    output step_ctl_t         ctl_o
);
    // step = {half, lane[1:0], sub[1:0]}
    logic       diag;
    logic [1:0] lane;
    logic [1:0] sub;
    idx_t       wa, wb, wc, wd;

    assign diag = step_i[4];
    assign lane = step_i[3:2];
    assign sub  = step_i[1:0];

    always_comb begin
        // Row r holds words 4r..4r+3; diagonal half shifts row r by r lanes.
        wa = {2'd0, lane};
        wb = {2'd1, lane + (diag ? 2'd1 : 2'd0)};
        wc = {2'd2, lane + (diag ? 2'd2 : 2'd0)};
        wd = {2'd3, lane + (diag ? 2'd3 : 2'd0)};

        if (!sub[0]) begin
            ctl_o.tgt = wa;
            ctl_o.src = wb;
            ctl_o.mix = wd;
        end else begin
            ctl_o.tgt = wc;
            ctl_o.src = wd;
            ctl_o.mix = wb;
        end

        case (sub)
            2'd0:    ctl_o.rot = ROT_W'(16);
            2'd1:    ctl_o.rot = ROT_W'(12);
            2'd2:    ctl_o.rot = ROT_W'(8);
            default: ctl_o.rot = ROT_W'(7);
        endcase
    end

    // The two written words must differ, or one write would be lost (R4).
    always_comb begin
        p_distinct_writes_r4: assert (ctl_o.tgt != ctl_o.mix)
            else $error("step table writes one word twice");
        p_distinct_rows_r5: assert (ctl_o.tgt[3:2] != ctl_o.src[3:2])
            else $error("step table adds a word to its own row");
    end

endmodule

// File: rtl/chacha_arx_unit.sv
module chacha_arx_unit
    import chacha_perm_pkg::*;
(
    input  word_t            tgt_i,
    input  word_t            src_i,
    input  word_t            mix_i,
    input  logic [ROT_W-1:0] rot_i,
    output word_t            sum_o,
    output word_t            mixed_o
);
    word_t                 xored;
    logic [2*WORD_W-1:0]   doubled;

    always_comb begin
        sum_o   = tgt_i + src_i;
        xored   = mix_i ^ sum_o;
        doubled = {xored, xored} << rot_i;
        mixed_o = doubled[2*WORD_W-1:WORD_W];
    end

    // A nonzero rotate keeps the xor result's population (R4).
    always_comb begin
        p_rotate_keeps_bits_r4: assert ($countones(mixed_o) == $countones(xored))
            else $error("rotator dropped bits");
    end

endmodule

// File: rtl/chacha_perm_core.sv
module chacha_perm_core
    import chacha_perm_pkg::*;
#(
    parameter int DOUBLE_ROUNDS = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [STATE_W-1:0] state_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [STATE_W-1:0] state_o
);
    localparam int RND_W = (DOUBLE_ROUNDS > 1) ? $clog2(DOUBLE_ROUNDS) : 1;
    localparam logic [RND_W-1:0]  LAST_ROUND = RND_W'(DOUBLE_ROUNDS - 1);
    localparam logic [STEP_W-1:0] LAST_STEP  = STEP_W'(STEPS_PER_DR - 1);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [STEP_W-1:0] step;
        logic [RND_W-1:0]  round;
        state_t            st;
    } regs_t;

    regs_t     r_q, r_d;
    step_ctl_t ctl;
    word_t     sum_w, mixed_w;

    chacha_step_table u_table (
        .step_i (r_q.step),
        .ctl_o  (ctl)
    );

    chacha_arx_unit u_arx (
        .tgt_i   (r_q.st[ctl.tgt]),
        .src_i   (r_q.st[ctl.src]),
        .mix_i   (r_q.st[ctl.mix]),
        .rot_i   (ctl.rot),
        .sum_o   (sum_w),
        .mixed_o (mixed_w)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (!r_q.busy) begin
            if (start_i) begin
                r_d.st    = state_i;
                r_d.busy  = 1'b1;
                r_d.step  = '0;
                r_d.round = '0;
            end
        end else begin
            r_d.st[ctl.tgt] = sum_w;
            r_d.st[ctl.mix] = mixed_w;
            if (r_q.step == LAST_STEP) begin
                r_d.step = '0;
                if (r_q.round == LAST_ROUND) begin
                    r_d.round = '0;
                    r_d.busy  = 1'b0;
                    r_d.done  = 1'b1;
                end else begin
                    r_d.round = r_q.round + 1'b1;
                end
            end else begin
                r_d.step = r_q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o  = r_q.busy;
    assign done_o  = r_q.done;
    assign state_o = r_q.st;

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        r_q.done |=> !r_q.done);

    p_done_after_last_r2: assert property (@(posedge clk) disable iff (rst)
        (r_q.busy && r_q.step == LAST_STEP && r_q.round == LAST_ROUND)
            |=> (r_q.done && !r_q.busy));

    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        r_q.done |-> !r_q.busy);

    p_start_accept_r7: assert property (@(posedge clk) disable iff (rst)
        (!r_q.busy && start_i) |=> (r_q.busy && r_q.step == '0 && r_q.round == '0));

    p_step_advance_r8: assert property (@(posedge clk) disable iff (rst)
        (r_q.busy && r_q.step != LAST_STEP)
            |=> (r_q.busy && r_q.step == $past(r_q.step) + 1'b1));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!r_q.busy && !start_i) |=> $stable(r_q.st));

    p_round_bound_r3: assert property (@(posedge clk) disable iff (rst)
        r_q.round <= LAST_ROUND);

endmodule

// File: tb/tb_chacha_perm_core.sv
module tb_chacha_perm_core;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [511:0] state_i = '0;
    logic         busy_o, done_o;
    logic [511:0] state_o;

    int checks = 0;
    int errors = 0;
    int cycle  = 0;
    logic prev_done = 1'b0;

    logic [511:0] exp_q[$];
    int           cyc_q[$];

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cycle <= cycle + 1;

    chacha_perm_core dut (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .state_i (state_i),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .state_o (state_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rl(input logic [31:0] v, input int n);
        return (v << n) | (v >> (32 - n));
    endfunction

    function automatic logic [127:0] qr(input logic [31:0] a, b, c, d);
        a = a + b; d = rl(d ^ a, 16);
        c = c + d; b = rl(b ^ c, 12);
        a = a + b; d = rl(d ^ a, 8);
        c = c + d; b = rl(b ^ c, 7);
        return {a, b, c, d};
    endfunction

    // Independent model: column then diagonal sets (R5, R6), ten times.
    function automatic logic [511:0] model(input logic [511:0] in);
        logic [31:0]  x[16];
        logic [127:0] o;
        logic [511:0] res;
        int           s[8][4];
        s[0] = '{0, 4, 8, 12}; s[1] = '{1, 5, 9, 13};
        s[2] = '{2, 6, 10, 14}; s[3] = '{3, 7, 11, 15};
        s[4] = '{0, 5, 10, 15}; s[5] = '{1, 6, 11, 12};
        s[6] = '{2, 7, 8, 13}; s[7] = '{3, 4, 9, 14};
        for (int i = 0; i < 16; i++) x[i] = in[32*i +: 32];
        for (int r = 0; r < 10; r++) begin
            for (int g = 0; g < 8; g++) begin
                o = qr(x[s[g][0]], x[s[g][1]], x[s[g][2]], x[s[g][3]]);
                x[s[g][0]] = o[127:96]; x[s[g][1]] = o[95:64];
                x[s[g][2]] = o[63:32];  x[s[g][3]] = o[31:0];
            end
        end
        for (int i = 0; i < 16; i++) res[32*i +: 32] = x[i];
        return res;
    endfunction

    // Monitor: pops the scoreboard on every completion pulse.
    always @(negedge clk) begin
        if (!rst && done_o) begin
            chk(!prev_done, "R2", "done wider than one cycle", 512'(prev_done), 512'(0));
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11", "done with nothing pending", 512'(1), 512'(0));
            end else begin
                logic [511:0] e;
                int           c0;
                e  = exp_q.pop_front();
                c0 = cyc_q.pop_front();
                chk(cycle - c0 == 320, "R2", "latency", 512'(cycle - c0), 512'(320));
                chk(state_o === e, "R3/R4/R5/R6", "permuted state", state_o, e);
            end
        end
        prev_done = done_o;
    end

    task automatic run_block(input logic [511:0] v, input bit noise);
        logic [511:0] e;
        e = model(v);
        while (busy_o) @(negedge clk);
        start_i = 1'b1; state_i = v;
        exp_q.push_back(e); cyc_q.push_back(cycle + 1);
        @(negedge clk);
        start_i = 1'b0; state_i = ~v;
        chk(busy_o === 1'b1, "R7", "busy after start", 512'(busy_o), 512'(1));
        if (noise) begin
            for (int k = 0; k < 4; k++) begin
                repeat (40) @(negedge clk);
                start_i = 1'b1; state_i = {16{32'hdead_0000 + 32'(k)}};
                @(negedge clk);
                start_i = 1'b0;
            end
        end
        while (!done_o) @(negedge clk);
        chk(busy_o === 1'b0, "R7", "busy low in done cycle", 512'(busy_o), 512'(0));
        @(negedge clk);
        chk(done_o === 1'b0, "R2", "done dropped", 512'(done_o), 512'(0));
        repeat (5) @(negedge clk);
        chk(state_o === e, "R10", "idle hold", state_o, e);
    endtask

    initial begin
        logic [511:0] v;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk(busy_o === 1'b0, "R1", "busy after reset", 512'(busy_o), 512'(0));
        chk(done_o === 1'b0, "R1", "done after reset", 512'(done_o), 512'(0));
        chk(state_o === '0, "R1", "state after reset", state_o, '0);

        // R9: zero in, zero out
        run_block('0, 1'b0);
        chk(state_o === '0, "R9", "zero state", state_o, '0);

        for (int i = 0; i < 16; i++) v[32*i +: 32] = 32'(i);
        run_block(v, 1'b0);

        v = {16{32'hffff_ffff}};
        run_block(v, 1'b0);

        // R8: extra starts while busy carry different data
        v[127:0]   = {32'h6b206574, 32'h79622d32, 32'h3320646e, 32'h61707865};
        for (int i = 4; i < 16; i++) v[32*i +: 32] = 32'h0302_0100 * 32'(i) + 32'(i * 7);
        run_block(v, 1'b1);

        for (int i = 0; i < 16; i++) v[32*i +: 32] = 32'h9e37_79b9 * 32'(i + 1);
        run_block(v, 1'b0);

        // R11: reset mid-run
        start_i = 1'b1; state_i = v;
        @(negedge clk);
        start_i = 1'b0;
        repeat (100) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk(busy_o === 1'b0, "R11", "busy after abort", 512'(busy_o), 512'(0));
        begin
            int seen = 0;
            for (int k = 0; k < 400; k++) begin
                @(negedge clk);
                if (done_o) seen++;
            end
            chk(seen == 0, "R11", "no done after abort", 512'(seen), 512'(0));
        end
        v = ~v;
        run_block(v, 1'b0);

        chk(exp_q.size() == 0, "R2", "pending results", 512'(exp_q.size()), 512'(0));
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule